// File: doc/BRIEF.md
# Parity Bus Transceiver With Latched Error Flag

This block moves a data byte between two buses. The narrow side (A) carries only data. The wide side (B) carries the same data plus one parity bit. Every data bit is complemented as it crosses the block, in either direction. When data goes from A to B, the block adds a parity bit so that the whole B word holds an odd number of ones. When data comes from B, the block checks all B bits and reports an active-low error whenever the count of ones is even. The error output models an open-collector line: a flag plus an enable that can only pull the line low.

Two active-low output enables choose the direction:
- With only the B-side enable asserted, data goes from A to B.
- With only the A-side enable asserted, data goes from B to A.
- With neither asserted, both bus drivers are off and the buses are isolated.
- With both asserted, data goes from A to B but the parity bit is complemented. This deliberately sends a bad word, so that the receiving checker can be tested.

The error flag passes through a storage stage controlled by a latch enable and an active-low clear. With the latch enable high, the flag follows the checker directly. On each rising clock edge while the latch enable is high, the storage stage also captures the check result. With the latch enable low, the flag shows the value stored at the last such edge. The clear wins over the latch enable.

Top module: `ptx_parity_xcvr`

## Requirements
- R1: With oeBN low and oeAN high, bOe is 1, aOe is 0 and bOut[DATA_W-1:0] equals the bitwise complement of aIn.
- R2: With oeAN low and oeBN high, aOe is 1, bOe is 0 and aOut equals the bitwise complement of bIn[DATA_W-1:0].
- R3: In the A-to-B mode of R1, bOut[DATA_W] (the parity bit, the most significant bit) makes the full bOut word hold an odd number of ones.
- R4: The checker reports an error when bIn, parity bit included, holds an even number of ones. This holds whichever driver is enabled.
- R5: With errLatchEn high and errClrN high, errN is 0 in the same cycle that bIn holds an even number of ones, and 1 otherwise.
- R6: With both oeAN and oeBN low, bOe is 1, aOe is 0, bOut[DATA_W-1:0] is still the complement of aIn, and bOut holds an even number of ones.
- R7: With both oeAN and oeBN high, aOe and bOe are both 0.
- R8: While errClrN is low, errN is 1 whatever the state of errLatchEn. A rising clock edge during the clear leaves the stored flag at no-error, so errN stays 1 after the clear is released with errLatchEn low.
- R9: With errLatchEn low and errClrN high, errN shows the result captured at the last rising clock edge where errLatchEn was high and errClrN high. Later changes on bIn have no effect on it.
- R10: errOe is 1 exactly when errN is 0, so the error line is only ever pulled low.
- R11: An active-low rstN clears the stored flag to no-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stored error flag |
| rstN | input | 1 | Asynchronous active-low reset |
| oeAN | input | 1 | Active-low enable for the A-side driver |
| oeBN | input | 1 | Active-low enable for the B-side driver |
| errLatchEn | input | 1 | High: flag follows the checker and is sampled each edge; low: hold |
| errClrN | input | 1 | Active-low clear of the error flag, wins over errLatchEn |
| aIn | input | DATA_W | Data seen on the A pads |
| aOut | output | DATA_W | Data driven onto the A pads |
| aOe | output | 1 | Drive enable for the A pads |
| bIn | input | DATA_W+1 | Data plus parity (MSB) seen on the B pads |
| bOut | output | DATA_W+1 | Data plus generated parity (MSB) driven onto the B pads |
| bOe | output | 1 | Drive enable for the B pads |
| errN | output | 1 | Active-low parity-error flag |
| errOe | output | 1 | Pull-low enable of the open-collector error line |

## Verification
The bench builds the block with its default width of eight data bits. At this width, every one of the 256 A-side bytes can be swept through both the normal and the forced-error A-to-B modes. Every one of the 512 B-side words can likewise be swept through the checker and the B-to-A path. The parity and complement results are recomputed by counting bits in the bench. At this small size, the storage sequences can be walked step by step: hold against later bus changes, clear while holding, and clear winning over the latch enable.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef struct packed {
    logic driveA;    // A pads driven (B-to-A)
    logic driveB;    // B pads driven (A-to-B)
    logic forceInv;  // complement the generated parity bit
    logic clearFlag; // force flag and store to no-error
    logic passLive;  // flag follows the checker, store samples it
  } ptxStrobes_t;
endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic        oeAN,
  input  logic        oeBN,
  input  logic        errLatchEn,
  input  logic        errClrN,
  output ptxStrobes_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.driveB    = ~oeBN;
    strobes.driveA    = ~oeAN & oeBN;
    strobes.forceInv  = ~oeAN & ~oeBN;
    strobes.clearFlag = ~errClrN;
    strobes.passLive  = errLatchEn & errClrN;
  end
endmodule

// File: rtl/ptx_datapath.sv
module ptx_datapath
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptxStrobes_t       strobes,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W:0]   bIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W:0]   bOut,
  output logic              errFlag
);
  localparam int B_W = DATA_W + 1;

  logic [DATA_W-1:0] toB;
  logic [DATA_W-1:0] toA;
  logic              genParity;
  logic              liveErr;
  logic              heldErr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign toB[i] = ~aIn[i];
    assign toA[i] = ~bIn[i];
  end

  // Odd parity over the B-side data plus parity bit
  assign genParity = ~(^toB) ^ strobes.forceInv;
  assign liveErr   = ~(^bIn[B_W-1:0]);

  assign bOut = {genParity, toB};
  assign aOut = toA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  heldErr <= 1'b0;
    else if (strobes.clearFlag) heldErr <= 1'b0;
    else if (strobes.passLive)  heldErr <= liveErr;
  end

  always_comb begin
    if (strobes.clearFlag)     errFlag = 1'b0;
    else if (strobes.passLive) errFlag = liveErr;
    else                       errFlag = heldErr;
  end
endmodule

// File: rtl/ptx_parity_xcvr.sv
module ptx_parity_xcvr
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oeAN,
  input  logic              oeBN,
  input  logic              errLatchEn,
  input  logic              errClrN,
  input  logic [DATA_W-1:0] aIn,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  input  logic [DATA_W:0]   bIn,
  output logic [DATA_W:0]   bOut,
  output logic              bOe,
  output logic              errN,
  output logic              errOe
);
  ptxStrobes_t strobes;
  logic        errFlag;

  ptx_ctrl u_ctrl (
    .oeAN(oeAN), .oeBN(oeBN), .errLatchEn(errLatchEn),
    .errClrN(errClrN), .strobes(strobes)
  );

  ptx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut), .errFlag(errFlag)
  );

  assign aOe   = strobes.driveA;
  assign bOe   = strobes.driveB;
  assign errN  = ~errFlag;
  assign errOe = errFlag;
endmodule

// File: rtl/ptx_parity_xcvr_chk.sv
module ptx_parity_xcvr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              oeAN,
  input logic              oeBN,
  input logic              errLatchEn,
  input logic              errClrN,
  input logic [DATA_W-1:0] aIn,
  input logic [DATA_W-1:0] aOut,
  input logic              aOe,
  input logic [DATA_W:0]   bIn,
  input logic [DATA_W:0]   bOut,
  input logic              bOe,
  input logic              errN,
  input logic              errOe
);
  AST_A2B_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!oeBN) |-> (bOe && !aOe && bOut[DATA_W-1:0] == ~aIn)); // R1
  AST_B2A_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!oeAN && oeBN) |-> (aOe && !bOe && aOut == ~bIn[DATA_W-1:0])); // R2
  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (!oeBN && oeAN) |-> (^bOut)); // R3
  AST_FORCED_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (!oeBN && !oeAN) |-> !(^bOut)); // R6
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    (oeAN && oeBN) |-> (!aOe && !bOe)); // R7
  AST_LIVE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (errLatchEn && errClrN) |-> (errN == ^bIn)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!errClrN) |-> (errN && !errOe)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!errLatchEn && errClrN && $past(!errLatchEn && errClrN)) |-> $stable(errN)); // R9
  AST_PULL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    errOe |-> !errN); // R10
endmodule

bind ptx_parity_xcvr ptx_parity_xcvr_chk #(.DATA_W(DATA_W)) chkInst (.*);

// File: tb/ptx_parity_xcvr_test.sv
module ptx_parity_xcvr_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          oeAN = 1'b1, oeBN = 1'b1, errLatchEn = 1'b0, errClrN = 1'b1;
  logic [DW-1:0] aIn = '0;
  logic [DW:0]   bIn = '0;
  logic [DW-1:0] aOut;
  logic [DW:0]   bOut;
  logic          aOe, bOe, errN, errOe;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  ptx_parity_xcvr #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .oeAN(oeAN), .oeBN(oeBN), .errLatchEn(errLatchEn),
    .errClrN(errClrN), .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn),
    .bOut(bOut), .bOe(bOe), .errN(errN), .errOe(errOe)
  );

  function automatic int ones(input logic [DW:0] v);
    int n = 0;
    for (int i = 0; i <= DW; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepNeg();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #400000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) stepNeg();
    // R11: reset state, store empty, flag shows held value
    #1 check("R11 errN after reset", {31'd0, errN}, 32'd1);
    check("R10 errOe after reset", {31'd0, errOe}, 32'd0);
    rstN = 1'b1;
    stepNeg();

    // R7 isolation
    oeAN = 1'b1; oeBN = 1'b1; #1;
    check("R7 aOe", {31'd0, aOe}, 32'd0);
    check("R7 bOe", {31'd0, bOe}, 32'd0);

    // R1 R3 A-to-B sweep
    oeAN = 1'b1; oeBN = 1'b0;
    for (int v = 0; v < 256; v++) begin
      stepNeg(); aIn = v[DW-1:0]; #1;
      check("R1 bOe", {31'd0, bOe}, 32'd1);
      check("R1 data", {24'd0, bOut[DW-1:0]}, {24'd0, ~v[7:0]});
      check("R3 odd ones", ones(bOut) % 2, 32'd1);
    end

    // R6 forced-error sweep
    oeAN = 1'b0; oeBN = 1'b0;
    for (int v = 0; v < 256; v++) begin
      stepNeg(); aIn = v[DW-1:0]; #1;
      check("R6 oe", {30'd0, aOe, bOe}, 32'd1);
      check("R6 data", {24'd0, bOut[DW-1:0]}, {24'd0, ~v[7:0]});
      check("R6 even ones", ones(bOut) % 2, 32'd0);
    end

    // R2 R4 R5 R10 B-to-A sweep with live flag
    oeAN = 1'b0; oeBN = 1'b1; errLatchEn = 1'b1;
    for (int v = 0; v < 512; v++) begin
      stepNeg(); bIn = v[DW:0]; #1;
      check("R2 oe", {30'd0, aOe, bOe}, 32'd2);
      check("R2 data", {24'd0, aOut}, {24'd0, ~v[7:0]});
      check("R4 R5 live errN", {31'd0, errN}, (ones(v[DW:0]) % 2 == 1) ? 32'd1 : 32'd0);
      check("R10 errOe", {31'd0, errOe}, {31'd0, ~errN});
    end

    // R4 check runs while B is driven
    oeAN = 1'b1; oeBN = 1'b0;
    stepNeg(); bIn = 9'h003; #1;
    check("R4 check while driving B", {31'd0, errN}, 32'd0);

    // R9 hold captured error against later changes
    stepNeg(); bIn = 9'h000; // even ones: error, captured at next edge
    stepNeg(); errLatchEn = 1'b0; bIn = 9'h001; #1;
    check("R9 hold error", {31'd0, errN}, 32'd0);
    stepNeg(); bIn = 9'h007; #1;
    check("R9 hold ignores bIn", {31'd0, errN}, 32'd0);

    // R8 clear while holding
    stepNeg(); errClrN = 1'b0; #1;
    check("R8 clear forces no-error", {31'd0, errN}, 32'd1);
    check("R8 errOe off", {31'd0, errOe}, 32'd0);
    stepNeg(); errClrN = 1'b1; #1;
    check("R8 stays clear after release", {31'd0, errN}, 32'd1);

    // R8 clear wins over latch enable
    stepNeg(); bIn = 9'h000; errLatchEn = 1'b1; errClrN = 1'b0; #1;
    check("R8 clear over enable", {31'd0, errN}, 32'd1);
    stepNeg(); errLatchEn = 1'b0; errClrN = 1'b1; #1;
    check("R8 nothing captured during clear", {31'd0, errN}, 32'd1);

    // R9 hold of a no-error sample
    stepNeg(); errLatchEn = 1'b1; bIn = 9'h001;
    stepNeg(); errLatchEn = 1'b0; bIn = 9'h000; #1;
    check("R9 hold no-error", {31'd0, errN}, 32'd1);

    // R11 reset clears a held error
    stepNeg(); errLatchEn = 1'b1; bIn = 9'h000;
    stepNeg(); errLatchEn = 1'b0; #1;
    check("R9 held error before reset", {31'd0, errN}, 32'd0);
    rstN = 1'b0; #1;
    check("R11 reset clears held flag", {31'd0, errN}, 32'd1);
    stepNeg(); rstN = 1'b1;
    stepNeg();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule